// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block connects a processor's register bus to one PS/2 keyboard or mouse. The device drives the serial clock. The block takes in device-to-host frames and places each byte in a one-deep receive holding register. It sends host bytes from a one-deep transmit holding register. Before each send it runs the request-to-send sequence: the clock is held low for a programmed number of peripheral clocks, and then data is pulled low. Both PS/2 lines are open-drain. Each line is modelled as a sampled input plus an output-enable that pulls the line low when set.

Software controls the block through eight 32-bit registers. It sets and clears the receive and transmit enables with write-one command bits. It reads a status word and selects which status bits raise the interrupt, using a set, clear and read-back mask trio. It also programs the inhibit length. The register bus is a plain read/write strobe interface with no back-pressure. A transfer is taken in every cycle that `bus_valid` is high. Read data is combinational in that same cycle. The only read side effect is on the receive holding register. The serial data moves under the device's clock, so it has no handshake. The transmit path's flow control is the pair of status bits for a free holding register and an empty transmitter, which software polls before writing.

Register offsets (byte addresses): control 0x00, receive data 0x04, transmit data 0x08, status 0x10, mask set 0x14, mask clear 0x18, mask read 0x1C, prescale 0x24.

Top module: `ps2_host_ctrl`

## Requirements
- R1: After reset the status word reads 0x003, the mask reads 0 and the prescale register reads 100. Receive is disabled, so the clock output-enable is 1 and the data output-enable is 0. `irq` is 0.
- R2: A control write sets receive-enable with bit 0, clears it with bit 1, sets transmit-enable with bit 8 and clears it with bit 9. A clear bit wins over a set bit. While receive is disabled and no send is active, the block pulls the PS/2 clock low.
- R3: A device frame has 11 bits: a start bit 0, eight data bits LSB first, odd parity and a stop bit. Each bit is sampled on a device clock falling edge after a two-flop synchronizer. The frame loads the byte into the receive data register and sets status bit 4.
- R4: Status bit 9 is set when the received frame's parity is not odd. It describes the byte that is currently held.
- R5: If a frame completes while bit 4 is still set, status bit 5 is set and the new byte replaces the old one. Reading the receive data register clears bits 4, 5 and 9.
- R6: Status bit 0 shows that the transmit holding register is free. Bit 1 shows that the holding register is free and no send is in progress. A transmit-data write is accepted only when transmit is enabled and the holding register is free. Any other transmit-data write is ignored.
- R7: A send starts with the clock pulled low for `max(prescale,1)` cycles, then one more cycle with both lines low. After that the clock is released and data stays low as the start bit.
- R8: On each of the next ten device falling edges the block presents the next bit: data LSB first, then odd parity, then a released stop bit.
- R9: On the 11th falling edge the block samples the data line. If it is high there, status bit 8 (missing acknowledge) is set. The next accepted transmit-data write clears it.
- R10: A transmit-disable command drops any pending byte, aborts a send in progress, releases both lines and leaves status bits 0 and 1 set.
- R11: Writing ones to the mask-set register sets mask bits. Writing ones to the mask-clear register clears them. The mask-read register returns the mask. `irq` is the OR over all status bits ANDed with the mask.
- R12: The prescale register is 12 bits wide. A written value above 4095 is stored as 4095.
- R13: Control bit 15 returns every register to its reset value and aborts any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt request |
| ps2_clk_i | input | 1 | Sampled PS/2 clock line |
| ps2_clk_oe | output | 1 | 1 pulls the PS/2 clock low |
| ps2_dat_i | input | 1 | Sampled PS/2 data line |
| ps2_dat_oe | output | 1 | 1 pulls the PS/2 data line low |

## Verification
Register writes take effect at the clock edge that closes the strobe cycle. Status and `irq` are therefore valid one cycle after a write or read side effect. A device falling edge is seen two to three cycles after the line drops. A received byte or an acknowledge result is therefore due a few cycles after the last falling edge. The bench waits half a PS/2 clock period, twenty cycles, before reading any of these. The inhibit length is due at an exact cycle count. The bench counts, on falling clock edges, how many cycles the clock output-enable stays high from the first cycle after the transmit-data write, and expects prescale plus one.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
  // register byte offsets
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_RHR  = 'h04;
  localparam int OFS_THR  = 'h08;
  localparam int OFS_STAT = 'h10;
  localparam int OFS_MSET = 'h14;
  localparam int OFS_MCLR = 'h18;
  localparam int OFS_MRD  = 'h1C;
  localparam int OFS_PRE  = 'h24;

  // control command bits
  localparam int CTRL_RX_ON  = 0;
  localparam int CTRL_RX_OFF = 1;
  localparam int CTRL_TX_ON  = 8;
  localparam int CTRL_TX_OFF = 9;
  localparam int CTRL_SRST   = 15;

  // status / mask bit positions
  localparam int ST_TXRDY   = 0;
  localparam int ST_TXEMPTY = 1;
  localparam int ST_RXRDY   = 4;
  localparam int ST_OVR     = 5;
  localparam int ST_NACK    = 8;
  localparam int ST_PAR     = 9;
  localparam int ST_W       = 10;
  localparam logic [ST_W-1:0] ST_IMPL = 10'b11_0011_0011;

  localparam int BYTE_W   = 8;
  localparam int TXSEQ_W  = BYTE_W + 2;   // data, parity, stop

  typedef enum logic [2:0] {
    TX_IDLE, TX_INH, TX_REQ, TX_REL, TX_SHIFT, TX_ACK
  } tx_state_e;
endpackage

// File: rtl/ps2h_sync_edge.sv
module ps2h_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_in,
  input  logic dat_in,
  output logic clk_s,
  output logic dat_s,
  output logic fall
);
  logic [STAGES-1:0] c_sh, d_sh;
  logic              c_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_sh   <= '1;
      d_sh   <= '1;
      c_prev <= 1'b1;
    end else begin
      c_sh   <= {c_sh[STAGES-2:0], clk_in};
      d_sh   <= {d_sh[STAGES-2:0], dat_in};
      c_prev <= c_sh[STAGES-1];
    end
  end

  assign clk_s = c_sh[STAGES-1];
  assign dat_s = d_sh[STAGES-1];
  assign fall  = c_prev & ~c_sh[STAGES-1];
endmodule

// File: rtl/ps2h_rx.sv
module ps2h_rx
  import ps2h_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fall,
  input  logic              dat_s,
  output logic              done,
  output logic [BYTE_W-1:0] byte_o,
  output logic              perr
);
  localparam int CNT_W   = $clog2(BYTE_W + 3);
  localparam int PAR_POS = BYTE_W + 1;
  localparam int STP_POS = BYTE_W + 2;

  logic [CNT_W-1:0]  pos;
  logic [BYTE_W-1:0] sh;
  logic              par_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      sh     <= '0;
      par_q  <= 1'b0;
      done   <= 1'b0;
      byte_o <= '0;
      perr   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        pos <= '0;
      end else if (fall) begin
        if (pos == '0) begin
          if (!dat_s) pos <= CNT_W'(1);
        end else if (pos <= CNT_W'(BYTE_W)) begin
          sh  <= {dat_s, sh[BYTE_W-1:1]};
          pos <= pos + CNT_W'(1);
        end else if (pos == CNT_W'(PAR_POS)) begin
          par_q <= dat_s;
          pos   <= pos + CNT_W'(1);
        end else if (pos == CNT_W'(STP_POS)) begin
          done   <= 1'b1;
          byte_o <= sh;
          perr   <= ~(^{sh, par_q});
          pos    <= '0;
        end else begin
          pos <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/ps2h_tx.sv
module ps2h_tx
  import ps2h_pkg::*;
#(
  parameter int PSR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [PSR_W-1:0]  pre_i,
  input  logic              fall,
  input  logic              clk_s,
  input  logic              dat_s,
  output logic              idle,
  output logic              clk_oe,
  output logic              dat_oe,
  output logic              nack_pulse
);
  localparam int BIT_W = $clog2(TXSEQ_W);

  tx_state_e          st;
  logic [PSR_W-1:0]   cnt;
  logic [TXSEQ_W-1:0] seq;
  logic [BIT_W-1:0]   bitn;
  logic               drv_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= TX_IDLE;
      cnt        <= '0;
      seq        <= '0;
      bitn       <= '0;
      drv_low    <= 1'b0;
      nack_pulse <= 1'b0;
    end else begin
      nack_pulse <= 1'b0;
      if (abort) begin
        st      <= TX_IDLE;
        drv_low <= 1'b0;
      end else begin
        case (st)
          TX_IDLE: if (start) begin
            seq <= {1'b1, ~^byte_i, byte_i};
            cnt <= (pre_i == '0) ? PSR_W'(1) : pre_i;
            st  <= TX_INH;
          end
          TX_INH: begin
            if (cnt <= PSR_W'(1)) begin
              st      <= TX_REQ;
              drv_low <= 1'b1;
            end else begin
              cnt <= cnt - PSR_W'(1);
            end
          end
          TX_REQ: begin
            st   <= TX_REL;
            bitn <= '0;
          end
          TX_REL: if (clk_s) st <= TX_SHIFT;
          TX_SHIFT: if (fall) begin
            drv_low <= ~seq[0];
            seq     <= seq >> 1;
            if (bitn == BIT_W'(TXSEQ_W - 1)) st <= TX_ACK;
            else bitn <= bitn + BIT_W'(1);
          end
          TX_ACK: if (fall) begin
            nack_pulse <= dat_s;
            drv_low    <= 1'b0;
            st         <= TX_IDLE;
          end
          default: st <= TX_IDLE;
        endcase
      end
    end
  end

  assign idle   = (st == TX_IDLE);
  assign clk_oe = (st == TX_INH) || (st == TX_REQ);
  assign dat_oe = drv_low;
endmodule

// File: rtl/ps2_host_ctrl.sv
module ps2_host_ctrl
  import ps2h_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PSR_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_RST     = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              ps2_clk_i,
  output logic              ps2_clk_oe,
  input  logic              ps2_dat_i,
  output logic              ps2_dat_oe
);
  localparam logic [PSR_W-1:0] PSR_DEF = PSR_W'(PRE_RST);

  logic wr, rd;
  logic wr_ctrl, wr_thr, wr_mset, wr_mclr, wr_pre, rd_rhr;
  logic srst, tx_dis_cmd, thr_accept, tx_start;

  logic              rx_en, tx_en;
  logic [BYTE_W-1:0] thr_q, rhr_q;
  logic              thr_full, rxrdy_q, ovr_q, par_q, nack_q;
  logic [ST_W-1:0]   mask_q, stat;
  logic [PSR_W-1:0]  psr_q;

  logic              clk_s, dat_s, fall;
  logic              rx_done, rx_perr;
  logic [BYTE_W-1:0] rx_byte;
  logic              tx_idle, tx_busy, tx_clk_oe, tx_dat_oe, tx_nack;

  // decode
  assign wr      = bus_valid & bus_write;
  assign rd      = bus_valid & ~bus_write;
  assign wr_ctrl = wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_thr  = wr && (bus_addr == ADDR_W'(OFS_THR));
  assign wr_mset = wr && (bus_addr == ADDR_W'(OFS_MSET));
  assign wr_mclr = wr && (bus_addr == ADDR_W'(OFS_MCLR));
  assign wr_pre  = wr && (bus_addr == ADDR_W'(OFS_PRE));
  assign rd_rhr  = rd && (bus_addr == ADDR_W'(OFS_RHR));

  assign srst       = wr_ctrl & bus_wdata[CTRL_SRST];
  assign tx_dis_cmd = wr_ctrl & bus_wdata[CTRL_TX_OFF];
  assign thr_accept = wr_thr & tx_en & ~thr_full;
  assign tx_start   = thr_full & tx_idle & tx_en;
  assign tx_busy    = ~tx_idle;

  // enables
  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
    end else if (wr_ctrl) begin
      rx_en <= (rx_en | bus_wdata[CTRL_RX_ON]) & ~bus_wdata[CTRL_RX_OFF];
      tx_en <= (tx_en | bus_wdata[CTRL_TX_ON]) & ~bus_wdata[CTRL_TX_OFF];
    end
  end

  // transmit holding register and acknowledge flag
  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      thr_q    <= '0;
      thr_full <= 1'b0;
      nack_q   <= 1'b0;
    end else begin
      if (tx_dis_cmd) begin
        thr_full <= 1'b0;
      end else if (thr_accept) begin
        thr_q    <= bus_wdata[BYTE_W-1:0];
        thr_full <= 1'b1;
      end else if (tx_start) begin
        thr_full <= 1'b0;
      end
      if (thr_accept)   nack_q <= 1'b0;
      else if (tx_nack) nack_q <= 1'b1;
    end
  end

  // receive holding register and flags
  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      rhr_q   <= '0;
      rxrdy_q <= 1'b0;
      ovr_q   <= 1'b0;
      par_q   <= 1'b0;
    end else if (rx_done) begin
      rhr_q   <= rx_byte;
      rxrdy_q <= 1'b1;
      par_q   <= rx_perr;
      ovr_q   <= (ovr_q | rxrdy_q) & ~rd_rhr;
    end else if (rd_rhr) begin
      rxrdy_q <= 1'b0;
      ovr_q   <= 1'b0;
      par_q   <= 1'b0;
    end
  end

  // interrupt mask and prescaler
  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      mask_q <= '0;
      psr_q  <= PSR_DEF;
    end else begin
      if (wr_mset)      mask_q <= (mask_q | bus_wdata[ST_W-1:0]) & ST_IMPL;
      else if (wr_mclr) mask_q <= mask_q & ~bus_wdata[ST_W-1:0];
      if (wr_pre) begin
        if (|bus_wdata[31:PSR_W]) psr_q <= '1;
        else                      psr_q <= bus_wdata[PSR_W-1:0];
      end
    end
  end

  // status word
  always_comb begin
    stat             = '0;
    stat[ST_TXRDY]   = ~thr_full;
    stat[ST_TXEMPTY] = ~thr_full & tx_idle;
    stat[ST_RXRDY]   = rxrdy_q;
    stat[ST_OVR]     = ovr_q;
    stat[ST_NACK]    = nack_q;
    stat[ST_PAR]     = par_q;
  end

  assign irq = |(stat & mask_q);

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        ADDR_W'(OFS_RHR):  bus_rdata = 32'(rhr_q);
        ADDR_W'(OFS_STAT): bus_rdata = 32'(stat);
        ADDR_W'(OFS_MRD):  bus_rdata = 32'(mask_q);
        ADDR_W'(OFS_PRE):  bus_rdata = 32'(psr_q);
        default:           bus_rdata = '0;
      endcase
    end
  end

  ps2h_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_in (ps2_clk_i),
    .dat_in (ps2_dat_i),
    .clk_s  (clk_s),
    .dat_s  (dat_s),
    .fall   (fall)
  );

  ps2h_rx u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (srst | ~rx_en | tx_busy),
    .fall   (fall),
    .dat_s  (dat_s),
    .done   (rx_done),
    .byte_o (rx_byte),
    .perr   (rx_perr)
  );

  ps2h_tx #(.PSR_W(PSR_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (srst | tx_dis_cmd),
    .start      (tx_start),
    .byte_i     (thr_q),
    .pre_i      (psr_q),
    .fall       (fall),
    .clk_s      (clk_s),
    .dat_s      (dat_s),
    .idle       (tx_idle),
    .clk_oe     (tx_clk_oe),
    .dat_oe     (tx_dat_oe),
    .nack_pulse (tx_nack)
  );

  assign ps2_clk_oe = tx_idle ? ~rx_en : tx_clk_oe;
  assign ps2_dat_oe = tx_dat_oe;
endmodule

// File: rtl/ps2h_checker.sv
module ps2h_checker
  import ps2h_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PSR_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq,
  input logic              ps2_clk_oe,
  input logic              ps2_dat_oe,
  input logic [ST_W-1:0]   stat,
  input logic [ST_W-1:0]   mask_q,
  input logic [PSR_W-1:0]  psr_q,
  input logic              rx_done,
  input logic              rd_rhr,
  input logic              srst
);
  logic wr_c;
  assign wr_c = bus_valid && bus_write;

  assert_empty_needs_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat[ST_TXEMPTY] |-> stat[ST_TXRDY]);

  assert_mask_clear_quiets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && bus_addr == ADDR_W'(OFS_MCLR) && bus_wdata == 32'hFFFF_FFFF) |=> !irq);

  assert_read_clears_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rhr && !rx_done) |=> !stat[ST_RXRDY]);

  assert_overrun_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && stat[ST_RXRDY] && !rd_rhr && !srst) |=> stat[ST_OVR]);

  assert_tx_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[CTRL_TX_OFF])
      |=> (stat[ST_TXEMPTY] && !ps2_dat_oe));

  assert_soft_reset_R13: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (mask_q == '0 && ps2_clk_oe));

  assert_prescale_sat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && bus_addr == ADDR_W'(OFS_PRE) && (|bus_wdata[31:PSR_W])) |=> (psr_q == '1));
endmodule

bind ps2_host_ctrl ps2h_checker #(.ADDR_W(ADDR_W), .PSR_W(PSR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .irq        (irq),
  .ps2_clk_oe (ps2_clk_oe),
  .ps2_dat_oe (ps2_dat_oe),
  .stat       (stat),
  .mask_q     (mask_q),
  .psr_q      (psr_q),
  .rx_done    (rx_done),
  .rd_rhr     (rd_rhr),
  .srst       (srst)
);

// File: tb/ps2_host_ctrl_test.sv
module ps2_host_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 20;
  localparam logic [7:0] A_CTRL = 8'h00, A_RHR = 8'h04, A_THR = 8'h08, A_STAT = 8'h10,
                         A_MSET = 8'h14, A_MCLR = 8'h18, A_MRD = 8'h1C, A_PRE = 8'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, ps2_clk_oe, ps2_dat_oe, ps2_clk_i, ps2_dat_i;
  logic        dev_clk = 1'b1, dev_dat = 1'b1;
  int          tests = 0, fails = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ps2_clk_i = dev_clk & ~ps2_clk_oe;
  assign ps2_dat_i = dev_dat & ~ps2_dat_oe;

  ps2_host_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .ps2_clk_i(ps2_clk_i), .ps2_clk_oe(ps2_clk_oe),
    .ps2_dat_i(ps2_dat_i), .ps2_dat_oe(ps2_dat_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // device-to-host frame
  task automatic dev_send(input logic [7:0] b, input bit bad_par);
    logic [10:0] fr;
    fr = {1'b1, (~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      dev_dat = fr[i];
      wait_cyc(HALF); dev_clk = 1'b0;
      wait_cyc(HALF); dev_clk = 1'b1;
    end
    dev_dat = 1'b1;
    wait_cyc(HALF);
  endtask

  // host-to-device frame, device side; called right after the THR write
  task automatic dev_recv(input bit give_ack, output int inh, output logic start_low,
                          output logic [9:0] bits);
    int guard = 0;
    inh = 0;
    while (!ps2_clk_oe && guard < 2000) begin @(negedge clk); guard++; end
    while (ps2_clk_oe && guard < 20000) begin inh++; guard++; @(negedge clk); end
    start_low = ps2_dat_i;
    for (int i = 0; i < 10; i++) begin
      wait_cyc(HALF); dev_clk = 1'b0;
      wait_cyc(HALF); dev_clk = 1'b1;
      bits[i] = ps2_dat_i;
    end
    if (give_ack) dev_dat = 1'b0;
    wait_cyc(HALF); dev_clk = 1'b0;
    wait_cyc(HALF); dev_clk = 1'b1;
    dev_dat = 1'b1;
    wait_cyc(HALF);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bread(A_STAT, d); chk("R1 status after reset", d, 32'h003);
    bread(A_MRD, d);  chk("R1 mask after reset", d, 32'h0);
    bread(A_PRE, d);  chk("R1 prescale after reset", d, 32'd100);
    chk("R1 clock inhibited", 32'(ps2_clk_oe), 32'd1);
    chk("R1 data released", 32'(ps2_dat_oe), 32'd0);
    chk("R1 irq low", 32'(irq), 32'd0);
  endtask

  task automatic t_prescale;
    logic [31:0] d;
    bwrite(A_PRE, 32'd5000); bread(A_PRE, d); chk("R12 saturate", d, 32'd4095);
    bwrite(A_PRE, 32'd30);   bread(A_PRE, d); chk("R12 plain value", d, 32'd30);
  endtask

  task automatic t_enable;
    bwrite(A_CTRL, 32'h0000_0003);   // on+off together: off wins
    chk("R2 rx off wins", 32'(ps2_clk_oe), 32'd1);
    bwrite(A_CTRL, 32'h0000_0101);
    chk("R2 rx enabled releases clock", 32'(ps2_clk_oe), 32'd0);
  endtask

  task automatic t_rx_basic;
    logic [31:0] d;
    dev_send(8'h3C, 1'b0);
    bread(A_STAT, d);
    chk("R3 byte ready", 32'(d[4]), 32'd1);
    chk("R4 parity ok", 32'(d[9]), 32'd0);
    bread(A_RHR, d);  chk("R3 data 3C", d, 32'h3C);
    bread(A_STAT, d); chk("R5 read clears ready", 32'(d[4]), 32'd0);
  endtask

  task automatic t_rx_parity;
    logic [31:0] d;
    dev_send(8'hA7, 1'b1);
    bread(A_STAT, d); chk("R4 parity error flagged", 32'(d[9]), 32'd1);
    bread(A_RHR, d);  chk("R3 data A7", d, 32'hA7);
    bread(A_STAT, d); chk("R5 read clears parity", 32'(d[9]), 32'd0);
  endtask

  task automatic t_rx_overrun;
    logic [31:0] d;
    dev_send(8'h11, 1'b0);
    dev_send(8'h22, 1'b0);
    bread(A_STAT, d); chk("R5 overrun and ready", d & 32'h30, 32'h30);
    bread(A_RHR, d);  chk("R5 newer byte kept", d, 32'h22);
    bread(A_STAT, d); chk("R5 flags cleared", d & 32'h230, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    bwrite(A_MSET, 32'h10);
    bread(A_MRD, d); chk("R11 mask readback", d, 32'h10);
    chk("R11 irq idle", 32'(irq), 32'd0);
    dev_send(8'h55, 1'b0);
    chk("R11 irq on byte", 32'(irq), 32'd1);
    bwrite(A_MCLR, 32'hFFFF_FFFF);
    chk("R11 irq masked", 32'(irq), 32'd0);
    bread(A_MRD, d); chk("R11 mask cleared", d, 32'h0);
    bread(A_RHR, d); chk("R3 data 55", d, 32'h55);
  endtask

  task automatic t_tx(input logic [7:0] b, input bit ack);
    int inh;
    logic st;
    logic [9:0] bits;
    logic [31:0] d;
    bwrite(A_THR, 32'(b));
    dev_recv(ack, inh, st, bits);
    chk("R7 inhibit cycles", 32'(inh), 32'd31);
    chk("R7 start bit low", 32'(st), 32'd0);
    chk("R8 data bits", 32'(bits[7:0]), 32'(b));
    chk("R8 odd parity", 32'(bits[8]), 32'(~^b));
    chk("R8 stop released", 32'(bits[9]), 32'd1);
    bread(A_STAT, d);
    chk("R6 empty after send", d & 32'h3, 32'h3);
    chk("R9 ack flag", 32'(d[8]), 32'(!ack));
  endtask

  task automatic t_abort;
    logic [31:0] d;
    bwrite(A_PRE, 32'd300);
    bwrite(A_THR, 32'h5A);
    wait_cyc(20);
    bread(A_STAT, d);
    chk("R9 write clears nack", 32'(d[8]), 32'd0);
    chk("R6 busy not empty", 32'(d[1]), 32'd0);
    chk("R7 clock held during inhibit", 32'(ps2_clk_oe), 32'd1);
    bwrite(A_CTRL, 32'h200);
    chk("R10 clock released", 32'(ps2_clk_oe), 32'd0);
    chk("R10 data released", 32'(ps2_dat_oe), 32'd0);
    bread(A_STAT, d); chk("R10 empty after abort", d & 32'h3, 32'h3);
    bwrite(A_THR, 32'h77);
    wait_cyc(40);
    bread(A_STAT, d); chk("R6 write ignored when disabled", d & 32'h3, 32'h3);
    chk("R6 no inhibit when disabled", 32'(ps2_clk_oe), 32'd0);
    bwrite(A_PRE, 32'd30);
  endtask

  task automatic t_srst;
    logic [31:0] d;
    bwrite(A_MSET, 32'h3FF);
    bwrite(A_CTRL, 32'h8000);
    bread(A_MRD, d);  chk("R13 mask reset", d, 32'h0);
    bread(A_STAT, d); chk("R13 status reset", d, 32'h003);
    bread(A_PRE, d);  chk("R13 prescale reset", d, 32'd100);
    chk("R13 rx disabled inhibits", 32'(ps2_clk_oe), 32'd1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_prescale;
    t_enable;
    t_rx_basic;
    t_rx_parity;
    t_rx_overrun;
    t_irq;
    t_tx(8'hA5, 1'b1);
    t_tx(8'h80, 1'b1);
    t_tx(8'h0F, 1'b0);
    t_abort;
    bwrite(A_CTRL, 32'h100);
    t_tx(8'h3E, 1'b1);
    t_srst;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule